// File: doc/BRIEF.md
# Block Lock Protection Unit

This unit guards the alterable contents of a sixteen-block flash array. It keeps one lock bit per erasable block and a single one-time permanent lock bit. For each erase, word-write or lock-configuration request it decides whether the operation may go ahead. When it refuses, it returns the status-register error bits that the controller should set. It also answers identifier reads with the lock state of any block and of the permanent lock.

Two pin conditions can bypass a block lock: a high level on the write-protect pin, or the reset pin held at its raised programming voltage. Once the permanent lock is set, neither condition bypasses a block lock any longer. The permanent lock itself can only be set with the reset pin raised, and it can never be cleared. Lock storage models non-volatile cells. It is unlocked at power-up and is not touched by the logic reset.

A request is sampled on a clock edge while `req_valid` is high. The verdict appears on the response outputs one cycle later. Any lock change is applied on that same edge.

Top module: `blk_lock_guard`

## Requirements
- R1: An erase (kind 0) or word write (kind 1) to a block whose lock bit is clear is permitted with no error bits, whatever the pin levels and the permanent lock.
- R2: While the permanent lock is clear, an erase or word write to a locked block is permitted exactly when `wp_hi` or `rst_raised` is high.
- R3: While the permanent lock is set, an erase or word write to a locked block is refused for every combination of `wp_hi` and `rst_raised`.
- R4: A refused request reports error bits in `resp_err` as follows: erase gives bits 1 and 5 (8'h22), word write gives bits 1 and 4 (8'h12), and any lock configuration (kinds 2, 3, 4) gives bits 1, 4 and 5 (8'h32). A permitted request reports 8'h00.
- R5: Set-block-lock (kind 2) sets only the lock bit of the block named by the top four bits of `req_addr`. It is permitted only when the permanent lock is clear and `wp_hi` or `rst_raised` is high.
- R6: Clear-all-locks (kind 3) clears all sixteen block lock bits in one operation. It is permitted only when the permanent lock is clear and `wp_hi` or `rst_raised` is high.
- R7: Set-permanent-lock (kind 4) is permitted only when `rst_raised` is high, and it is idempotent once set. Nothing ever clears the permanent lock.
- R8: `id_data` for an address whose low 15 bits equal 2 returns, in bit 0, the lock bit of the block given by the top four bits (1 = locked). Address 19'h00003 returns the permanent lock in bit 0. Every other bit, and every other address, reads 0.
- R9: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Lock changes are visible on `id_data` from that cycle on. `rst_n` low clears the response outputs, and requests made while `rst_n` is low are ignored.
- R10: All lock bits are clear at power-up and keep their values across `rst_n` pulses.
- R11: A reserved kind (5, 6 or 7) is refused with `resp_err` 8'h00 and changes no lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous logic reset (lock storage excluded) |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | 0 erase, 1 word write, 2 set block lock, 3 clear all locks, 4 set permanent lock |
| req_addr | input | 19 | Word address; top four bits select the block |
| wp_hi | input | 1 | Write-protect pin is high |
| rst_raised | input | 1 | Reset pin is at the raised programming voltage |
| resp_valid | output | 1 | Verdict valid |
| resp_permit | output | 1 | Request may proceed |
| resp_err | output | 8 | Status-register bits to set on refusal |
| id_addr | input | 19 | Identifier read address |
| id_data | output | 16 | Identifier read data |

## Verification
The bench targets the permanent lock overriding both bypass pins. A design that still honoured `wp_hi` or `rst_raised` after the permanent lock was set would permit erases of locked blocks. It also checks that clear-all and set-block are refused once the permanent lock is set and that setting the permanent lock needs the raised reset level; a lenient design would silently change lock state, which the identifier reads expose. Lock survival across `rst_n` is checked by reading a block lock after a reset pulse, where a design that reset its storage would read 0. Refusals of each kind are compared against their distinct error masks, so swapped or missing error bits are reported.

// File: rtl/lockg_pkg.sv
package lockg_pkg;
  localparam logic [2:0] K_ERASE   = 3'd0;
  localparam logic [2:0] K_WRITE   = 3'd1;
  localparam logic [2:0] K_SETBLK  = 3'd2;
  localparam logic [2:0] K_CLRALL  = 3'd3;
  localparam logic [2:0] K_SETPERM = 3'd4;

  localparam int SR_LOCKFAIL = 1;
  localparam int SR_PROGFAIL = 4;
  localparam int SR_ERASFAIL = 5;

  // pin-level bypass of a block lock
  function automatic logic pin_bypass(input logic wp, input logic raised);
    return wp | raised;
  endfunction

  function automatic logic is_alter(input logic [2:0] kind);
    return (kind == K_ERASE) || (kind == K_WRITE);
  endfunction

  function automatic logic is_config(input logic [2:0] kind);
    return (kind == K_SETBLK) || (kind == K_CLRALL) || (kind == K_SETPERM);
  endfunction

  // status bits to raise when the request is refused
  function automatic logic [7:0] refuse_bits(input logic [2:0] kind);
    logic [7:0] m;
    m = '0;
    if (kind == K_ERASE) begin
      m[SR_LOCKFAIL] = 1'b1;
      m[SR_ERASFAIL] = 1'b1;
    end else if (kind == K_WRITE) begin
      m[SR_LOCKFAIL] = 1'b1;
      m[SR_PROGFAIL] = 1'b1;
    end else if (is_config(kind)) begin
      m[SR_LOCKFAIL] = 1'b1;
      m[SR_PROGFAIL] = 1'b1;
      m[SR_ERASFAIL] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/lockg_policy.sv
module lockg_policy
  import lockg_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       blk_locked,
  input  logic       perm,
  input  logic       wp,
  input  logic       raised,
  output logic       permit,
  output logic [7:0] err_bits
);
  logic bypass;
  assign bypass = pin_bypass(wp, raised);

  always_comb begin
    unique case (kind)
      K_ERASE, K_WRITE: permit = !blk_locked || (!perm && bypass);
      K_SETBLK, K_CLRALL: permit = !perm && bypass;
      K_SETPERM: permit = raised;
      default: permit = 1'b0;
    endcase
    err_bits = permit ? 8'h00 : refuse_bits(kind);
  end

  // R3: the permanent lock beats every pin level
  always_comb begin
    if (perm && blk_locked && is_alter(kind))
      assert_perm_blocks_R3: assert (!permit) else $error("locked block altered under permanent lock");
  end
endmodule

// File: rtl/lockg_store.sv
module lockg_store
  import lockg_pkg::*;
#(
  parameter int NUM_BLK = 16,
  localparam int BLK_W = $clog2(NUM_BLK)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [2:0]         kind,
  input  logic [BLK_W-1:0]   blk_idx,
  output logic [NUM_BLK-1:0] locks,
  output logic               perm
);
  logic set_ev, clr_ev, perm_ev;
  assign set_ev  = upd_en && (kind == K_SETBLK);
  assign clr_ev  = upd_en && (kind == K_CLRALL);
  assign perm_ev = upd_en && (kind == K_SETPERM);

  // non-volatile cells: power-up value only, no logic reset
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_cell
    logic cell_q = 1'b0;
    always_ff @(posedge clk) begin
      if (clr_ev) cell_q <= 1'b0;
      else if (set_ev && (blk_idx == BLK_W'(i))) cell_q <= 1'b1;
    end
    assign locks[i] = cell_q;
  end

  logic perm_q = 1'b0;
  always_ff @(posedge clk) begin
    if (perm_ev) perm_q <= 1'b1;
  end
  assign perm = perm_q;

  assert_perm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perm |=> perm);
  assert_set_hits_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> locks[$past(blk_idx)]);
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (locks == '0));
endmodule

// File: rtl/lockg_idread.sv
module lockg_idread #(
  parameter int NUM_BLK = 16,
  parameter int OFS_W   = 15,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int ADDR_W = BLK_W + OFS_W
)(
  input  logic [ADDR_W-1:0]  id_addr,
  input  logic [NUM_BLK-1:0] locks,
  input  logic               perm,
  output logic [15:0]        id_data
);
  logic [BLK_W-1:0] sel_blk;
  logic [OFS_W-1:0] sel_ofs;
  assign sel_blk = id_addr[ADDR_W-1 -: BLK_W];
  assign sel_ofs = id_addr[OFS_W-1:0];

  always_comb begin
    id_data = '0;
    if (sel_ofs == OFS_W'(2)) id_data[0] = locks[sel_blk];
    else if (id_addr == ADDR_W'(3)) id_data[0] = perm;
  end
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import lockg_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int OFS_W   = 15,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int ADDR_W = BLK_W + OFS_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_hi,
  input  logic              rst_raised,
  output logic              resp_valid,
  output logic              resp_permit,
  output logic [7:0]        resp_err,
  input  logic [ADDR_W-1:0] id_addr,
  output logic [15:0]       id_data
);
  logic [NUM_BLK-1:0] locks_w;
  logic               perm_w;
  logic [BLK_W-1:0]   blk_idx;
  logic               permit_w;
  logic [7:0]         err_w;
  logic               upd_en;

  assign blk_idx = req_addr[ADDR_W-1 -: BLK_W];
  assign upd_en  = rst_n && req_valid && permit_w;

  lockg_policy u_policy (
    .kind(req_kind), .blk_locked(locks_w[blk_idx]), .perm(perm_w),
    .wp(wp_hi), .raised(rst_raised), .permit(permit_w), .err_bits(err_w)
  );

  lockg_store #(.NUM_BLK(NUM_BLK)) u_store (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .kind(req_kind),
    .blk_idx(blk_idx), .locks(locks_w), .perm(perm_w)
  );

  lockg_idread #(.NUM_BLK(NUM_BLK), .OFS_W(OFS_W)) u_id (
    .id_addr(id_addr), .locks(locks_w), .perm(perm_w), .id_data(id_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_permit <= 1'b0;
      resp_err    <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_permit <= permit_w;
        resp_err    <= err_w;
      end
    end
  end

  assert_resp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));
  assert_permit_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_permit) |-> (resp_err == 8'h00));
  assert_perm_needs_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perm_w) |-> $past(rst_raised && req_valid));
endmodule

// File: tb/blk_lock_guard_test.sv
`timescale 1ns/1ps
module blk_lock_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [18:0] req_addr = '0;
  logic        wp_hi = 1'b0;
  logic        rst_raised = 1'b0;
  logic        resp_valid, resp_permit;
  logic [7:0]  resp_err;
  logic [18:0] id_addr = '0;
  logic [15:0] id_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       m_lock[16];
  logic       m_perm = 1'b0;

  always #4 clk = ~clk;

  blk_lock_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .wp_hi(wp_hi), .rst_raised(rst_raised),
    .resp_valid(resp_valid), .resp_permit(resp_permit), .resp_err(resp_err),
    .id_addr(id_addr), .id_data(id_data)
  );

  function automatic logic [18:0] blk_base(input int b, input int ofs);
    return {b[3:0], ofs[14:0]};
  endfunction

  // driver: computes the verdict from the rules and updates the model
  task automatic send(input logic [2:0] k, input int b, input logic wp,
                      input logic rz, input string tag);
    logic ok;
    logic [7:0] e;
    logic lk;
    lk = m_lock[b];
    ok = 1'b0;
    case (k)
      3'd0, 3'd1: ok = (lk == 1'b0) ? 1'b1 : ((m_perm == 1'b0) && (wp || rz));
      3'd2, 3'd3: ok = (m_perm == 1'b0) && (wp || rz);
      3'd4: ok = rz;
      default: ok = 1'b0;
    endcase
    e = 8'h00;
    if (!ok) begin
      if (k == 3'd0) e = 8'h22;
      else if (k == 3'd1) e = 8'h12;
      else if (k <= 3'd4) e = 8'h32;
    end
    if (ok && k == 3'd2) m_lock[b] = 1'b1;
    if (ok && k == 3'd3) for (int i = 0; i < 16; i++) m_lock[i] = 1'b0;
    if (ok && k == 3'd4) m_perm = 1'b1;
    @(negedge clk);
    req_kind = k; req_addr = blk_base(b, 123); wp_hi = wp; rst_raised = rz;
    req_valid = 1'b1;
    exp_q.push_back({ok, e});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops expectations as responses come out
  always @(negedge clk) begin
    if (resp_valid) begin
      logic [8:0] ex;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected response: actual permit=%0b expected none", resp_permit);
      end else begin
        ex = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({resp_permit, resp_err} !== ex) begin
          failures++;
          $display("FAIL %s: actual permit=%0b err=%h expected permit=%0b err=%h",
                   t, resp_permit, resp_err, ex[8], ex[7:0]);
        end
      end
    end
  end

  task automatic check_id(input logic [18:0] a, input logic [15:0] ex, input string tag);
    @(negedge clk);
    id_addr = a;
    #1;
    checks++;
    if (id_data !== ex) begin
      failures++;
      $display("FAIL %s: id addr %h actual %h expected %h", tag, a, id_data, ex);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_lock[i] = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset: actual resp_valid=%0b expected 0", resp_valid);
    end
    rst_n = 1'b1;
    // R10: power-up state is unlocked
    check_id(blk_base(7, 2), 16'h0000, "R10 power-up block");
    check_id(19'h00003, 16'h0000, "R10 power-up permanent");

    send(3'd0, 3, 1'b0, 1'b0, "R1 erase unlocked");
    send(3'd2, 3, 1'b0, 1'b0, "R5 set lock no bypass");
    check_id(blk_base(3, 2), 16'h0000, "R5 refused set leaves bit");
    send(3'd2, 3, 1'b1, 1'b0, "R5 set lock wp");
    check_id(blk_base(3, 2), 16'h0001, "R5 block 3 locked");
    check_id(blk_base(4, 2), 16'h0000, "R5 neighbour untouched");
    send(3'd0, 3, 1'b0, 1'b0, "R4 erase refused mask");
    send(3'd1, 3, 1'b0, 1'b0, "R4 write refused mask");
    send(3'd0, 3, 1'b1, 1'b0, "R2 erase via wp");
    send(3'd1, 3, 1'b0, 1'b1, "R2 write via raised reset");
    send(3'd2, 9, 1'b0, 1'b1, "R5 set lock raised");
    send(3'd3, 0, 1'b0, 1'b0, "R6 clear refused");
    check_id(blk_base(9, 2), 16'h0001, "R6 refused clear keeps bit");
    send(3'd3, 0, 1'b1, 1'b0, "R6 clear all");
    check_id(blk_base(3, 2), 16'h0000, "R6 block 3 cleared");
    check_id(blk_base(9, 2), 16'h0000, "R6 block 9 cleared");
    send(3'd2, 3, 1'b1, 1'b0, "R5 relock 3");
    send(3'd2, 15, 1'b1, 1'b0, "R5 lock 15");
    send(3'd7, 6, 1'b1, 1'b1, "R11 reserved kind");
    send(3'd5, 3, 1'b1, 1'b1, "R11 reserved kind 5");
    check_id(blk_base(6, 2), 16'h0000, "R11 no lock change");
    check_id(blk_base(3, 2), 16'h0001, "R11 lock kept");
    send(3'd4, 0, 1'b1, 1'b0, "R7 permanent refused");
    check_id(19'h00003, 16'h0000, "R7 permanent still clear");

    // R10: lock survives a reset pulse
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9 in reset: actual resp_valid=%0b expected 0", resp_valid);
    end
    @(negedge clk); rst_n = 1'b1;
    check_id(blk_base(3, 2), 16'h0001, "R10 lock after reset");
    check_id(blk_base(15, 2), 16'h0001, "R10 lock 15 after reset");

    send(3'd4, 0, 1'b0, 1'b1, "R7 permanent set");
    check_id(19'h00003, 16'h0001, "R7 permanent reads 1");
    send(3'd0, 3, 1'b1, 1'b1, "R3 erase locked under permanent");
    send(3'd1, 15, 1'b1, 1'b1, "R3 write locked under permanent");
    send(3'd0, 0, 1'b0, 1'b0, "R1 erase unlocked under permanent");
    send(3'd1, 8, 1'b1, 1'b0, "R1 write unlocked under permanent");
    send(3'd3, 0, 1'b1, 1'b1, "R6 clear refused under permanent");
    send(3'd2, 5, 1'b1, 1'b1, "R5 set refused under permanent");
    send(3'd4, 0, 1'b0, 1'b1, "R7 permanent idempotent");
    check_id(blk_base(3, 2), 16'h0001, "R6 lock kept under permanent");
    check_id(blk_base(5, 2), 16'h0000, "R5 no set under permanent");
    check_id(19'h00003, 16'h0001, "R7 permanent sticky");
    check_id(blk_base(3, 5), 16'h0000, "R8 other offset reads 0");
    check_id(19'h00002, 16'h0000, "R8 block 0 lock word");
    check_id(blk_base(15, 3), 16'h0000, "R8 offset 3 outside block 0");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule